// File: doc/BRIEF.md
# Frequency Ramp Sweep Controller

This block produces the frequency control word for a synthesizer chirp. When enabled it holds a programmed start word. A trigger launches a sweep, and each step then moves the word by a programmed step size, either up or down. After the programmed number of steps the engine parks on the last word and waits for the next trigger. In one-way operation that trigger makes the word hop straight back to the start value. In two-way operation it starts a leg in the opposite direction, which walks the word back to the start value.

Stepping is either automatic or manual. In automatic stepping each word is held for a programmed dwell count of clocks. In single-step operation every step waits for its own trigger. Triggers come from a software pulse, from the rising edge of an external pin after it has been synchronized, or from an automatic source that fires whenever the engine is waiting. The word feeds a fractional modulator that reads it on every reference clock. The output is therefore a plain value with a one-cycle change strobe. There is no ready signal and no back-pressure, because the consumer can never stall.

Top module: `ramp_sweep_ctrl`

## Requirements
- R1: While reset is asserted and in the first cycle after it, freq_word is 0, and step_strobe and busy are 0.
- R2: While cfg_enable is 0, freq_word equals cfg_start_word from the next clock edge on, busy is 0, and triggers cause no stepping. Clearing cfg_enable in the middle of a sweep abandons that sweep.
- R3: A step adds cfg_step_size to the word when the direction is up and subtracts it when the direction is down. The arithmetic is modulo 2^24. A trigger in the idle state applies the first step on that same clock edge, in the direction given by cfg_start_down (0 = up, 1 = down).
- R4: With cfg_single_step = 0, every word produced by a step is held for cfg_dwell + 1 clocks before the next step. The sweep stops after cfg_num_steps steps.
- R5: With cfg_one_way = 1, the word stays on its last value after the final step. The next trigger reloads the start word and returns the engine to idle, and the trigger after that starts a new sweep.
- R6: With cfg_one_way = 0, a trigger after the final step starts a leg of cfg_num_steps steps in the opposite direction. Legs keep alternating direction in this way.
- R7: With cfg_single_step = 1, each step after the first needs its own trigger. Without a trigger the word does not change.
- R8: busy is 1 from the first step of a leg until the final step of that leg is applied. It is 0 while the engine is idle, while it waits after a leg, and while it is disabled.
- R9: step_strobe is 1 in exactly the cycles where freq_word differs from its value in the previous cycle.
- R10: cfg_trig_src selects the trigger source: 0 = sw_trig pulse, 1 = rising edge of ext_trig (through a two-stage synchronizer), 2 = automatic (fires whenever the engine waits), 3 = none. Triggers from a source that is not selected have no effect.
- R11: When cfg_num_steps is 0, triggers never start a sweep and the word stays at the start value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_enable | input | 1 | Ramp function enable; 0 holds the engine idle at the start word |
| cfg_start_word | input | 24 | Start frequency word |
| cfg_step_size | input | 24 | Step magnitude applied on each step |
| cfg_num_steps | input | 16 | Steps per leg |
| cfg_dwell | input | 16 | Extra hold clocks per word in automatic stepping |
| cfg_start_down | input | 1 | Initial direction: 0 up, 1 down |
| cfg_one_way | input | 1 | 1 = hop back to start, 0 = reverse each leg |
| cfg_single_step | input | 1 | 1 = each step waits for a trigger |
| cfg_trig_src | input | 2 | Trigger source select |
| sw_trig | input | 1 | Software trigger pulse |
| ext_trig | input | 1 | External trigger pin, asynchronous |
| freq_word | output | 24 | Current frequency word |
| step_strobe | output | 1 | One-cycle pulse when freq_word changes |
| busy | output | 1 | Sweep leg in progress |

## Verification
The sweep is driven upward in one-way automatic stepping with a nonzero dwell. This separates the per-word hold time from the leg length and shows the hop back to the start value. A downward two-way single-step sweep that crosses zero shows modulo wrap-around, the reversal of direction and the trigger gating of each step. Each trigger source is selected in turn while the other sources are pulsed. This tells the synchronized edge detection, the free-running automatic restart and the quiet "none" setting apart. A zero step count and a sweep disabled part-way through cover the cases where a sweep must not start and where it is abandoned.

// File: rtl/ramp_pkg.sv
package ramp_pkg;
  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_END  = 2'd2
  } sweep_state_e;

  typedef enum logic [1:0] {
    TRIG_SW   = 2'd0,
    TRIG_EXT  = 2'd1,
    TRIG_AUTO = 2'd2,
    TRIG_NONE = 2'd3
  } trig_src_e;
endpackage

// File: rtl/ramp_trig_sel.sv
module ramp_trig_sel #(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] src_sel,
  input  logic       sw_pulse,
  input  logic       ext_pin,
  output logic       trig
);
  import ramp_pkg::*;

  logic ext_s;
  logic ext_prev_q;
  logic ext_rise;

  generate
    if (SYNC_STAGES == 0) begin : g_nosync
      assign ext_s = ext_pin;
    end else begin : g_sync
      logic [SYNC_STAGES-1:0] sync_q;
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q <= '0;
        else        sync_q <= {sync_q[SYNC_STAGES-2:0], ext_pin};
      end
      assign ext_s = sync_q[SYNC_STAGES-1];
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ext_prev_q <= 1'b0;
    else        ext_prev_q <= ext_s;
  end

  assign ext_rise = ext_s & ~ext_prev_q;

  always_comb begin
    unique case (trig_src_e'(src_sel))
      TRIG_SW:   trig = sw_pulse;
      TRIG_EXT:  trig = ext_rise;
      TRIG_AUTO: trig = 1'b1;
      default:   trig = 1'b0;
    endcase
  end

  // R10: the "none" setting never produces a trigger
  a_r10_none_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (src_sel == 2'd3) |-> !trig);
endmodule

// File: rtl/ramp_dwell_timer.sv
module ramp_dwell_timer #(
  parameter int DW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          restart,
  input  logic [DW-1:0] dwell,
  output logic          expired
);
  logic [DW-1:0] cnt_q;

  assign expired = (cnt_q >= dwell);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        cnt_q <= '0;
    else if (restart)  cnt_q <= '0;
    else if (!expired) cnt_q <= cnt_q + 1'b1;
  end

  // R4: a restart always leaves the count at zero
  a_r4_restart_zero: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> (cnt_q == '0));
endmodule

// File: rtl/ramp_word_path.sv
module ramp_word_path #(
  parameter int FW = 24
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load_start,
  input  logic          step_en,
  input  logic          step_down,
  input  logic [FW-1:0] start_word,
  input  logic [FW-1:0] step_size,
  output logic [FW-1:0] word,
  output logic          strobe
);
  logic [FW-1:0] word_q;
  logic [FW-1:0] word_d;
  logic          strobe_q;

  always_comb begin
    word_d = word_q;
    if (load_start)   word_d = start_word;
    else if (step_en) word_d = step_down ? (word_q - step_size) : (word_q + step_size);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      word_q   <= '0;
      strobe_q <= 1'b0;
    end else begin
      word_q   <= word_d;
      strobe_q <= (word_d != word_q);
    end
  end

  assign word   = word_q;
  assign strobe = strobe_q;

  // R3: upward step adds the step size modulo 2^FW
  a_r3_step_up: assert property (@(posedge clk) disable iff (!rst_n)
    (step_en && !load_start && !step_down) |=> (word_q == $past(word_q) + $past(step_size)));
  // R3: downward step subtracts the step size modulo 2^FW
  a_r3_step_down: assert property (@(posedge clk) disable iff (!rst_n)
    (step_en && !load_start && step_down) |=> (word_q == $past(word_q) - $past(step_size)));
endmodule

// File: rtl/ramp_sweep_ctrl.sv
module ramp_sweep_ctrl #(
  parameter int FW          = 24,
  parameter int CW          = 16,
  parameter int DW          = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cfg_enable,
  input  logic [FW-1:0] cfg_start_word,
  input  logic [FW-1:0] cfg_step_size,
  input  logic [CW-1:0] cfg_num_steps,
  input  logic [DW-1:0] cfg_dwell,
  input  logic          cfg_start_down,
  input  logic          cfg_one_way,
  input  logic          cfg_single_step,
  input  logic [1:0]    cfg_trig_src,
  input  logic          sw_trig,
  input  logic          ext_trig,
  output logic [FW-1:0] freq_word,
  output logic          step_strobe,
  output logic          busy
);
  import ramp_pkg::*;

  localparam logic [CW:0] ONE_STEP = {{CW{1'b0}}, 1'b1};

  sweep_state_e  state_q, state_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          dir_q, dir_d;
  logic          load_start, step_en, step_down, timer_restart;
  logic          trig, expired, advance, no_steps;
  logic [CW:0]   cnt_next;

  ramp_trig_sel #(.SYNC_STAGES(SYNC_STAGES)) u_trig (
    .clk(clk), .rst_n(rst_n), .src_sel(cfg_trig_src),
    .sw_pulse(sw_trig), .ext_pin(ext_trig), .trig(trig)
  );

  ramp_dwell_timer #(.DW(DW)) u_dwell (
    .clk(clk), .rst_n(rst_n), .restart(timer_restart),
    .dwell(cfg_dwell), .expired(expired)
  );

  ramp_word_path #(.FW(FW)) u_word (
    .clk(clk), .rst_n(rst_n), .load_start(load_start), .step_en(step_en),
    .step_down(step_down), .start_word(cfg_start_word), .step_size(cfg_step_size),
    .word(freq_word), .strobe(step_strobe)
  );

  assign no_steps = (cfg_num_steps == '0);
  assign cnt_next = {1'b0, cnt_q} + ONE_STEP;
  assign advance  = cfg_single_step ? trig : expired;

  always_comb begin
    state_d       = state_q;
    cnt_d         = cnt_q;
    dir_d         = dir_q;
    load_start    = 1'b0;
    step_en       = 1'b0;
    step_down     = dir_q;
    timer_restart = 1'b0;
    if (!cfg_enable) begin
      state_d    = ST_IDLE;
      cnt_d      = '0;
      load_start = 1'b1;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          load_start = 1'b1;
          if (trig && !no_steps) begin
            load_start    = 1'b0;
            step_en       = 1'b1;
            step_down     = cfg_start_down;
            dir_d         = cfg_start_down;
            cnt_d         = {{(CW-1){1'b0}}, 1'b1};
            timer_restart = 1'b1;
            state_d       = (cfg_num_steps == {{(CW-1){1'b0}}, 1'b1}) ? ST_END : ST_RUN;
          end
        end
        ST_RUN: begin
          if (advance) begin
            step_en       = 1'b1;
            cnt_d         = cnt_next[CW-1:0];
            timer_restart = 1'b1;
            if (cnt_next >= {1'b0, cfg_num_steps}) state_d = ST_END;
          end
        end
        ST_END: begin
          if (trig) begin
            if (cfg_one_way) begin
              load_start = 1'b1;
              cnt_d      = '0;
              state_d    = ST_IDLE;
            end else if (!no_steps) begin
              step_en       = 1'b1;
              step_down     = ~dir_q;
              dir_d         = ~dir_q;
              cnt_d         = {{(CW-1){1'b0}}, 1'b1};
              timer_restart = 1'b1;
              state_d       = (cfg_num_steps == {{(CW-1){1'b0}}, 1'b1}) ? ST_END : ST_RUN;
            end
          end
        end
        default: state_d = ST_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      cnt_q   <= '0;
      dir_q   <= 1'b0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      dir_q   <= dir_d;
    end
  end

  assign busy = (state_q == ST_RUN);

  // R2: disabling forces idle at the start word on the next edge
  a_r2_disable_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_enable |=> (!busy && freq_word == $past(cfg_start_word)));
  // R9: strobe marks exactly the cycles where the word moved
  a_r9_strobe_on_change: assert property (@(posedge clk) disable iff (!rst_n)
    step_strobe == (freq_word != $past(freq_word)));
  // R7: in single-step mode the word holds without a trigger
  a_r7_single_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_enable && busy && cfg_single_step && !trig) |=> $stable(freq_word));
  // R4: in automatic stepping the word holds until the dwell expires
  a_r4_dwell_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_enable && busy && !cfg_single_step && !expired) |=> $stable(freq_word));
  // R11: a zero step count never starts a leg
  a_r11_zero_count: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_enable && no_steps && !busy) |=> !busy);
endmodule

// File: tb/ramp_sweep_ctrl_tb_top.sv
module ramp_sweep_ctrl_tb_top;
  localparam time CLK_PERIOD = 10ns;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        cfg_enable;
  logic [23:0] cfg_start_word, cfg_step_size;
  logic [15:0] cfg_num_steps, cfg_dwell;
  logic        cfg_start_down, cfg_one_way, cfg_single_step;
  logic [1:0]  cfg_trig_src;
  logic        sw_trig, ext_trig;
  logic [23:0] freq_word;
  logic        step_strobe, busy;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ramp_sweep_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .cfg_enable(cfg_enable),
    .cfg_start_word(cfg_start_word), .cfg_step_size(cfg_step_size),
    .cfg_num_steps(cfg_num_steps), .cfg_dwell(cfg_dwell),
    .cfg_start_down(cfg_start_down), .cfg_one_way(cfg_one_way),
    .cfg_single_step(cfg_single_step), .cfg_trig_src(cfg_trig_src),
    .sw_trig(sw_trig), .ext_trig(ext_trig),
    .freq_word(freq_word), .step_strobe(step_strobe), .busy(busy)
  );

  task automatic tick(int n = 1);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      #1;
    end
  endtask

  task automatic chk(string req, logic [23:0] act, logic [23:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic pulse_sw();
    sw_trig = 1'b1;
    tick();
    sw_trig = 1'b0;
  endtask

  task automatic restart_engine();
    cfg_enable = 1'b0;
    tick();
    cfg_enable = 1'b1;
    tick();
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    cfg_enable = 1'b0; cfg_start_word = 24'h100000; cfg_step_size = 24'h10;
    cfg_num_steps = 16'd4; cfg_dwell = 16'd2; cfg_start_down = 1'b0;
    cfg_one_way = 1'b1; cfg_single_step = 1'b0; cfg_trig_src = 2'd0;
    sw_trig = 1'b0; ext_trig = 1'b0;
    tick(3);
    chk("R1 word in reset", freq_word, 24'h0);
    chk("R1 busy in reset", {23'h0, busy}, 24'h0);
    rst_n = 1'b1;
    chk("R1 strobe after reset", {23'h0, step_strobe}, 24'h0);
    tick();
    chk("R2 disabled loads start", freq_word, 24'h100000);
    chk("R9 strobe on load", {23'h0, step_strobe}, 24'h1);
    pulse_sw();
    chk("R2 trigger ignored while disabled", freq_word, 24'h100000);
    chk("R9 no strobe when held", {23'h0, step_strobe}, 24'h0);
    chk("R2 busy low while disabled", {23'h0, busy}, 24'h0);
  endtask

  task automatic t_oneway_auto_up();
    cfg_start_word = 24'h000100; cfg_step_size = 24'h10; cfg_num_steps = 16'd4;
    cfg_dwell = 16'd2; cfg_start_down = 1'b0; cfg_one_way = 1'b1;
    cfg_single_step = 1'b0; cfg_trig_src = 2'd0;
    restart_engine();
    chk("R2 idle at start", freq_word, 24'h000100);
    pulse_sw();
    chk("R3 first step up", freq_word, 24'h000110);
    chk("R8 busy during leg", {23'h0, busy}, 24'h1);
    tick(2);
    chk("R4 held for dwell", freq_word, 24'h000110);
    tick();
    chk("R4 step after dwell+1", freq_word, 24'h000120);
    chk("R9 strobe on step", {23'h0, step_strobe}, 24'h1);
    tick(3);
    chk("R4 third step", freq_word, 24'h000130);
    tick(3);
    chk("R4 final step", freq_word, 24'h000140);
    chk("R8 busy clear at end", {23'h0, busy}, 24'h0);
    tick(10);
    chk("R5 parked after leg", freq_word, 24'h000140);
    pulse_sw();
    chk("R5 hop back to start", freq_word, 24'h000100);
    chk("R8 busy low after hop", {23'h0, busy}, 24'h0);
    tick(4);
    chk("R5 idle after hop", freq_word, 24'h000100);
    pulse_sw();
    chk("R5 new sweep starts", freq_word, 24'h000110);
    cfg_enable = 1'b0;
    tick();
    chk("R2 abandon mid sweep", freq_word, 24'h000100);
    chk("R2 busy cleared on disable", {23'h0, busy}, 24'h0);
  endtask

  task automatic t_twoway_single_down();
    cfg_start_word = 24'h000005; cfg_step_size = 24'h3; cfg_num_steps = 16'd2;
    cfg_dwell = 16'd0; cfg_start_down = 1'b1; cfg_one_way = 1'b0;
    cfg_single_step = 1'b1; cfg_trig_src = 2'd0;
    restart_engine();
    pulse_sw();
    chk("R3 first step down", freq_word, 24'h000002);
    tick(5);
    chk("R7 no step without trigger", freq_word, 24'h000002);
    chk("R8 busy while waiting step", {23'h0, busy}, 24'h1);
    pulse_sw();
    chk("R3 wrap below zero", freq_word, 24'hFFFFFF);
    chk("R8 busy clear after leg", {23'h0, busy}, 24'h0);
    pulse_sw();
    chk("R6 reverse leg up wraps", freq_word, 24'h000002);
    chk("R6 busy on reverse leg", {23'h0, busy}, 24'h1);
    pulse_sw();
    chk("R6 reverse leg ends at start", freq_word, 24'h000005);
    pulse_sw();
    chk("R6 next leg down again", freq_word, 24'h000002);
  endtask

  task automatic t_ext_src();
    cfg_start_word = 24'h001000; cfg_step_size = 24'h1; cfg_num_steps = 16'd3;
    cfg_dwell = 16'd0; cfg_start_down = 1'b0; cfg_one_way = 1'b1;
    cfg_single_step = 1'b0; cfg_trig_src = 2'd1;
    restart_engine();
    pulse_sw();
    chk("R10 sw ignored when ext selected", freq_word, 24'h001000);
    ext_trig = 1'b1;
    tick(8);
    chk("R10 ext edge runs sweep", freq_word, 24'h001003);
    tick(5);
    chk("R10 level held gives no new edge", freq_word, 24'h001003);
    ext_trig = 1'b0;
    tick(3);
    ext_trig = 1'b1;
    tick(6);
    chk("R10 second ext edge hops back", freq_word, 24'h001000);
    ext_trig = 1'b0;
    tick(3);
  endtask

  task automatic t_auto_src();
    cfg_enable = 1'b0;
    cfg_start_word = 24'h000020; cfg_step_size = 24'h10; cfg_num_steps = 16'd2;
    cfg_dwell = 16'd0; cfg_start_down = 1'b0; cfg_one_way = 1'b1;
    cfg_single_step = 1'b0; cfg_trig_src = 2'd2;
    tick();
    chk("R2 start before auto", freq_word, 24'h000020);
    cfg_enable = 1'b1;
    tick();
    chk("R10 auto starts at once", freq_word, 24'h000030);
    chk("R8 busy in auto leg", {23'h0, busy}, 24'h1);
    tick();
    chk("R10 auto last step", freq_word, 24'h000040);
    chk("R8 busy clear auto end", {23'h0, busy}, 24'h0);
    tick();
    chk("R5 auto hop back", freq_word, 24'h000020);
    chk("R9 strobe on hop", {23'h0, step_strobe}, 24'h1);
    tick();
    chk("R10 auto restarts", freq_word, 24'h000030);
    cfg_enable = 1'b0;
    cfg_trig_src = 2'd0;
    tick();
  endtask

  task automatic t_none_src();
    cfg_start_word = 24'h000050; cfg_step_size = 24'h1; cfg_num_steps = 16'd2;
    cfg_trig_src = 2'd3; cfg_one_way = 1'b1; cfg_single_step = 1'b0;
    restart_engine();
    pulse_sw();
    ext_trig = 1'b1;
    tick(6);
    ext_trig = 1'b0;
    tick(2);
    chk("R10 none source quiet", freq_word, 24'h000050);
    chk("R10 none source not busy", {23'h0, busy}, 24'h0);
  endtask

  task automatic t_zero_count();
    cfg_start_word = 24'h000777; cfg_step_size = 24'h5; cfg_num_steps = 16'd0;
    cfg_trig_src = 2'd0; cfg_one_way = 1'b0; cfg_single_step = 1'b0;
    restart_engine();
    pulse_sw();
    tick(2);
    chk("R11 zero count no sweep", freq_word, 24'h000777);
    chk("R11 zero count not busy", {23'h0, busy}, 24'h0);
  endtask

  initial begin
    t_reset();
    t_oneway_auto_up();
    t_twoway_single_down();
    t_ext_src();
    t_auto_src();
    t_none_src();
    t_zero_count();
    if (!done) begin
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1'b1;
      checks++;
      failures++;
      $display("FAIL watchdog: actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule